// File: doc/BRIEF.md
# Wake-Up Timer with Four Compare Points

A 32-bit wake-up counter that advances on ticks taken from one of three sources: the bus clock itself, a low-frequency oscillator tick, or an external clock tick. The two slow sources are modelled as single-cycle enable pulses in the bus clock domain. The selected tick passes through a prescaler before it moves the counter. The counter can step up or down. It either runs freely over the whole 32-bit range or runs periodically, wrapping at the value held in compare D.

Four 32-bit compare registers watch the count. A match sets a sticky flag. The flags are gated by two enable masks, one driving an interrupt output and one driving a wake output. Compare A can re-arm itself: on each match it adds a 12-bit interval to its own value. Software reaches every register over a 16-bit word interface. The 32-bit count is read as two halves. When freezing is enabled, reading the low half captures the high half, so that the pair of reads returns a coherent value.

Top module: `wakeup_timer`

## Requirements
- R1: After reset every register reads 0, the count is 0, and `irq` and `wake` are low.
- R2: The word map is: 0 control, 1 count low half, 2 count high half, 3/4 compare A low/high, 5/6 compare B, 7/8 compare C, 9/10 compare D, 11 interval (bits [11:0]), 12 flags (bits [3:0] = A,B,C,D), 13 enables (bits [3:0] interrupt mask A..D, bits [7:4] wake mask A..D). Reads are combinational from `addr` while `rd_en` is high.
- R3: Control bits [10:9] select the tick source: 00 is every bus clock, 01 is `lf_tick`, and 10 or 11 is `ext_tick`. Ticks from a source that is not selected have no effect on the count.
- R4: Control bits [1:0] set the prescale divide to 1, 16, 256 or 32768 selected-source ticks per count step, for the codes 00, 01, 10 and 11.
- R5: With the bus clock selected, prescale code 00 divides by 4 instead of 1.
- R6: Control bit 7 enables the timer. While it is clear, the count and the prescaler are held at zero.
- R7: In free-running mode (control bit 4 clear), counting up (control bit 2 clear) wraps from 0xFFFFFFFF to 0, and counting down wraps from 0 to 0xFFFFFFFF.
- R8: In periodic mode (control bit 4 set), an up count goes from compare D to 0, and a down count goes from 0 to compare D.
- R9: When a count step produces a value equal to a compare register, that register's flag is set. Flags stay set until a 1 is written to their bit in the flags word. If a set and a clear occur in the same cycle, the set wins.
- R10: `irq` is high when any flag is set whose interrupt mask bit is set. `wake` is high when any flag is set whose wake mask bit is set.
- R11: With control bit 5 set, a compare A match replaces compare A with its value plus the zero-extended interval, modulo 2^32. Without that bit, compare A changes only when software writes it.
- R12: With control bit 3 set, reading the low half of the count captures the high half. The next read of the high half returns the captured value and releases it, and later reads of the high half return the live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lf_tick | input | 1 | Low-frequency oscillator tick, one cycle wide |
| ext_tick | input | 1 | External clock tick, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
Counting is exercised in three ways. The free-running bus clock checks the divide-by-4 rule against divide-by-16. Hand-placed oscillator and external pulses check source selection, the 1-to-1 prescale and the 16-tick prescale. Each count position is then known exactly. Down-then-up runs across zero cross both free-running wrap points and also move the high half of the count, which is what the frozen split read must hide. Periodic runs with a small compare D show that the wrap goes to zero in one direction and to compare D in the other. The auto-increment runs confirm that compare A moves by the interval on each match and fires again at the new position.

// File: rtl/wakeup_timer.sv
module wakeup_timer #(
  parameter int DW  = 16,
  parameter int AW  = 4,
  parameter int IVW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lf_tick,
  input  logic          ext_tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          wake
);
  localparam int CW   = 2 * DW;
  localparam int PW   = 15;
  localparam int NCMP = 4;

  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_VLO  = AW'(1);
  localparam logic [AW-1:0] A_VHI  = AW'(2);
  localparam int            A_CMP0 = 3;
  localparam logic [AW-1:0] A_IVL  = AW'(11);
  localparam logic [AW-1:0] A_FLG  = AW'(12);
  localparam logic [AW-1:0] A_IEN  = AW'(13);

  localparam int B_DOWN = 2;
  localparam int B_FRZ  = 3;
  localparam int B_PER  = 4;
  localparam int B_AUTO = 5;
  localparam int B_EN   = 7;

  logic [DW-1:0]   ctrl;
  logic [CW-1:0]   cnt;
  logic [PW-1:0]   pre;
  logic [CW-1:0]   cmp [NCMP];
  logic [IVW-1:0]  ivl;
  logic [NCMP-1:0] flags;
  logic [2*NCMP-1:0] ien;
  logic [DW-1:0]   hold_hi;
  logic            hold_v;

  logic            en, src_tick, tick;
  logic [PW-1:0]   div_m1;
  logic [CW-1:0]   nxt;
  logic [NCMP-1:0] match;

  assign en = ctrl[B_EN];

  always_comb begin
    case (ctrl[10:9])
      2'b00:   src_tick = 1'b1;
      2'b01:   src_tick = lf_tick;
      default: src_tick = ext_tick;
    endcase
  end

  always_comb begin
    case (ctrl[1:0])
      2'b00:   div_m1 = (ctrl[10:9] == 2'b00) ? PW'(3) : PW'(0);
      2'b01:   div_m1 = PW'(15);
      2'b10:   div_m1 = PW'(255);
      default: div_m1 = PW'(32767);
    endcase
  end

  assign tick = en && src_tick && (pre >= div_m1);

  always_comb begin
    if (ctrl[B_DOWN])
      nxt = (ctrl[B_PER] && cnt == '0) ? cmp[NCMP-1] : cnt - CW'(1);
    else
      nxt = (ctrl[B_PER] && cnt == cmp[NCMP-1]) ? '0 : cnt + CW'(1);
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_match
    assign match[g] = tick && (nxt == cmp[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      cnt <= '0;
    end else if (!en) begin
      pre <= '0;
      cnt <= '0;
    end else begin
      if (src_tick) pre <= (pre >= div_m1) ? '0 : pre + PW'(1);
      if (tick) cnt <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      ivl   <= '0;
      ien   <= '0;
      flags <= '0;
    end else begin
      if (wr_en && addr == A_CTRL) ctrl <= wdata;
      if (wr_en && addr == A_IVL)  ivl  <= wdata[IVW-1:0];
      if (wr_en && addr == A_IEN)  ien  <= wdata[2*NCMP-1:0];
      flags <= (flags & ~((wr_en && addr == A_FLG) ? wdata[NCMP-1:0] : '0)) | match;
    end
  end

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    localparam logic [AW-1:0] LO = AW'(A_CMP0 + 2 * g);
    localparam logic [AW-1:0] HI = AW'(A_CMP0 + 2 * g + 1);
    always_ff @(posedge clk) begin
      if (!rst_n)
        cmp[g] <= '0;
      else if (wr_en && addr == LO)
        cmp[g][DW-1:0] <= wdata;
      else if (wr_en && addr == HI)
        cmp[g][CW-1:DW] <= wdata;
      else if (g == 0 && ctrl[B_AUTO] && match[g])
        cmp[g] <= cmp[g] + CW'(ivl);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_v  <= 1'b0;
      hold_hi <= '0;
    end else if (rd_en && addr == A_VHI) begin
      hold_v <= 1'b0;
    end else if (rd_en && addr == A_VLO && ctrl[B_FRZ]) begin
      hold_v  <= 1'b1;
      hold_hi <= cnt[CW-1:DW];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_CTRL: rdata = ctrl;
        A_VLO:  rdata = cnt[DW-1:0];
        A_VHI:  rdata = hold_v ? hold_hi : cnt[CW-1:DW];
        A_IVL:  rdata = DW'(ivl);
        A_FLG:  rdata = DW'(flags);
        A_IEN:  rdata = DW'(ien);
        default: begin
          for (int i = 0; i < NCMP; i++) begin
            if (addr == AW'(A_CMP0 + 2 * i))     rdata = cmp[i][DW-1:0];
            if (addr == AW'(A_CMP0 + 2 * i + 1)) rdata = cmp[i][CW-1:DW];
          end
        end
      endcase
    end
  end

  assign irq  = |(flags & ien[NCMP-1:0]);
  assign wake = |(flags & ien[2*NCMP-1:NCMP]);

endmodule

// File: rtl/wakeup_timer_chk.sv
module wakeup_timer_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   ctrl,
  input logic [2*DW-1:0] cnt,
  input logic [2*DW-1:0] cmp_a,
  input logic [2*DW-1:0] cmp_d,
  input logic [3:0]      flags,
  input logic [7:0]      ien,
  input logic            hold_v,
  input logic            irq,
  input logic            wake
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[7] |=> cnt == '0); // R6

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[7] |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1 || cnt == $past(cnt) - 1 ||
                 cnt == '0 || cnt == $past(cmp_d))); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(12)) |=> (flags & $past(flags)) == $past(flags)); // R9

  AST_OUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) || $rose(wake)) |-> (!$stable(flags) || !$stable(ien))); // R10

  AST_CMPA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[5] && !(wr_en && (addr == AW'(3) || addr == AW'(4)))) |=> $stable(cmp_a)); // R11

  AST_FREEZE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(1) && ctrl[3]) |=> hold_v); // R12
endmodule

bind wakeup_timer wakeup_timer_chk #(.DW(DW), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .ctrl(ctrl), .cnt(cnt), .cmp_a(cmp[0]), .cmp_d(cmp[3]), .flags(flags),
  .ien(ien), .hold_v(hold_v), .irq(irq), .wake(wake)
);

// File: tb/test_wakeup_timer.sv
module test_wakeup_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, lf_tick = 0, ext_tick = 0, wr_en = 0, rd_en = 0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq, wake;
  int checks = 0, errors = 0;

  wakeup_timer i_wakeup_timer (
    .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .ext_tick(ext_tick),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq(irq), .wake(wake)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // control word fields
  localparam logic [15:0] EN = 16'h0080, FRZ = 16'h0008, DN = 16'h0004,
                          PER = 16'h0010, AUTO = 16'h0020, SRC_LF = 16'h0200,
                          SRC_EXT = 16'h0400, PS16 = 16'h0001;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; addr = a; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse_lf(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lf_tick = 1; @(negedge clk); lf_tick = 0;
    end
  endtask

  task automatic pulse_ext(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_tick = 1; @(negedge clk); ext_tick = 0;
    end
  endtask

  task automatic set_cmp(int i, logic [31:0] v);
    wr(4'(3 + 2*i), v[15:0]);
    wr(4'(4 + 2*i), v[31:16]);
  endtask

  task automatic rd32(output logic [31:0] v);
    logic [15:0] lo, hi;
    rd(4'd1, lo); rd(4'd2, hi);
    v = {hi, lo};
  endtask

  task automatic clean();
    wr(4'd0, 16'h0);
    for (int i = 0; i < 4; i++) set_cmp(i, 32'h8000_0000 + 32'(i));
    wr(4'd13, 16'h0);
    wr(4'd12, 16'hF);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(4'd0, d);  chk("R1 ctrl", 32'(d), 0);
    rd(4'd1, d);  chk("R1 count", 32'(d), 0);
    rd(4'd12, d); chk("R1 flags", 32'(d), 0);
    rd(4'd3, d);  chk("R1 cmpA", 32'(d), 0);
    chk("R1 irq/wake", {30'b0, irq, wake}, 0);
  endtask

  task automatic t_bus_prescale();
    logic [15:0] d;
    clean();
    wr(4'd0, EN);
    repeat (40) @(negedge clk);
    rd(4'd1, d); chk("R5 bus div4", 32'(d), 10);
    wr(4'd0, 16'h0);
    rd(4'd1, d); chk("R6 disabled count zero", 32'(d), 0);
    wr(4'd0, EN | PS16);
    repeat (32) @(negedge clk);
    rd(4'd1, d); chk("R4 bus div16", 32'(d), 2);
  endtask

  task automatic t_source();
    logic [15:0] d;
    clean();
    wr(4'd0, EN | SRC_LF);
    pulse_ext(5);
    rd(4'd1, d); chk("R3 ext ignored when lf selected", 32'(d), 0);
    pulse_lf(3);
    rd(4'd1, d); chk("R3 lf counts", 32'(d), 3);
    wr(4'd0, 16'h0);
    wr(4'd0, EN | SRC_EXT);
    pulse_lf(4);
    pulse_ext(2);
    rd(4'd1, d); chk("R3 ext source", 32'(d), 2);
    wr(4'd0, 16'h0);
    wr(4'd0, EN | SRC_LF | PS16);
    pulse_lf(31);
    rd(4'd1, d); chk("R4 lf div16 after 31", 32'(d), 1);
    pulse_lf(1);
    rd(4'd1, d); chk("R4 lf div16 after 32", 32'(d), 2);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    clean();
    wr(4'd0, EN | SRC_LF | DN);
    pulse_lf(1);
    rd32(v); chk("R7 down wrap to all ones", v, 32'hFFFF_FFFF);
    wr(4'd0, EN | SRC_LF);
    pulse_lf(1);
    rd32(v); chk("R7 up wrap to zero", v, 0);
  endtask

  task automatic t_periodic();
    logic [15:0] d;
    clean();
    set_cmp(3, 32'd3);
    wr(4'd0, EN | SRC_LF | PER);
    pulse_lf(3);
    rd(4'd12, d); chk("R9 flag D on match", 32'(d), 32'h8);
    pulse_lf(2);
    rd(4'd1, d); chk("R8 periodic up wraps at D", 32'(d), 1);
    wr(4'd0, 16'h0);
    wr(4'd0, EN | SRC_LF | PER | DN);
    pulse_lf(1);
    rd(4'd1, d); chk("R8 periodic down reloads D", 32'(d), 3);
    pulse_lf(2);
    rd(4'd1, d); chk("R8 periodic down step", 32'(d), 1);
  endtask

  task automatic t_flags();
    logic [15:0] d;
    clean();
    set_cmp(1, 32'd2);
    wr(4'd13, 16'h0002);
    wr(4'd0, EN | SRC_LF);
    pulse_lf(1);
    chk("R10 no irq before match", {31'b0, irq}, 0);
    pulse_lf(1);
    rd(4'd12, d); chk("R9 flag B", 32'(d), 32'h2);
    chk("R10 irq from B", {31'b0, irq}, 1);
    chk("R10 wake masked", {31'b0, wake}, 0);
    wr(4'd13, 16'h0020);
    chk("R10 wake from B", {30'b0, irq, wake}, 1);
    pulse_lf(3);
    rd(4'd12, d); chk("R9 flag sticky", 32'(d), 32'h2);
    wr(4'd12, 16'h0001);
    rd(4'd12, d); chk("R9 clear other bit leaves B", 32'(d), 32'h2);
    wr(4'd12, 16'h0002);
    rd(4'd12, d); chk("R9 write one clears", 32'(d), 0);
    chk("R10 wake drops", {31'b0, wake}, 0);
  endtask

  task automatic t_autoinc();
    logic [15:0] d;
    clean();
    set_cmp(0, 32'd2);
    wr(4'd11, 16'h0003);
    wr(4'd0, EN | SRC_LF | AUTO);
    pulse_lf(2);
    rd(4'd3, d); chk("R11 cmpA advanced", 32'(d), 5);
    rd(4'd12, d); chk("R9 flag A", 32'(d), 32'h1);
    wr(4'd12, 16'h0001);
    pulse_lf(3);
    rd(4'd3, d); chk("R11 cmpA advanced again", 32'(d), 8);
    rd(4'd12, d); chk("R11 rearmed match", 32'(d), 32'h1);
    set_cmp(0, 32'hFFFF_FFFE);
    wr(4'd11, 16'h0FFF);
    wr(4'd0, 16'h0);
    wr(4'd0, EN | SRC_LF | AUTO | DN);
    pulse_lf(2);
    rd(4'd3, d); chk("R11 wrap lo", 32'(d), 32'h0FFD);
    rd(4'd4, d); chk("R11 wrap hi", 32'(d), 0);
    wr(4'd0, EN | SRC_LF);
    set_cmp(0, 32'd9);
    pulse_lf(20);
    rd(4'd3, d); chk("R11 no auto when bit clear", 32'(d), 9);
  endtask

  task automatic t_freeze();
    logic [15:0] d;
    clean();
    wr(4'd0, EN | SRC_LF | DN | FRZ);
    pulse_lf(1);
    rd(4'd1, d); chk("R12 low half", 32'(d), 32'hFFFF);
    wr(4'd0, EN | SRC_LF | FRZ);
    pulse_lf(1);
    rd(4'd2, d); chk("R12 frozen high half", 32'(d), 32'hFFFF);
    rd(4'd2, d); chk("R12 released high half", 32'(d), 0);
    wr(4'd0, EN | SRC_LF | DN);
    pulse_lf(1);
    rd(4'd1, d);
    wr(4'd0, EN | SRC_LF);
    pulse_lf(1);
    rd(4'd2, d); chk("R12 no capture without freeze", 32'(d), 0);
    rd(4'd0, d); chk("R2 ctrl readback", 32'(d), 32'(EN | SRC_LF));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bus_prescale();
    t_source();
    t_wrap();
    t_periodic();
    t_flags();
    t_autoinc();
    t_freeze();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule